// File: doc/BRIEF.md
# Three-Mode Parity Controller for Shared DRAM

This block sets the length of each access to a DRAM shared by several bus masters and applies byte-lane parity protection to it. On a write it produces one odd-parity bit per enabled byte lane for the array to store beside the data. On a read it compares the returned data with the returned parity bits, looking only at enabled lanes. Each access ends with a one-clock pulse on either the done output or the bus error output.

The mode input, sampled when an access starts, selects one of three policies. Unchecked mode runs every access at the base length and never reports errors. Deferred mode checks every read. A CPU read still finishes at the base length, and a bad CPU read only sets a sticky flag. Every later CPU access then ends in bus error until the flag is cleared. Any other master is stretched by one clock so that it learns of an error in the access itself. Strict mode stretches every access by one clock and reports errors at once. The DRAM array and its refresh and row/column timing are outside the block.

Top module: `dram_parity_ctrl`

## Requirements
- R1: Encoding: modeSel 0 is unchecked, 1 is deferred, and 2 or 3 is strict. masterId 0 is the CPU; any other value is a non-CPU master. In unchecked mode every access ends with cycDone 2 clocks after the start is sampled, even when the parity is bad.
- R2: parOut bit i equals the odd-parity bit of wrData byte i (bits 8i+7..8i), so the byte and the bit together hold an odd number of ones. The bit is 0 when byteEn[i] is low.
- R3: A read checks only the lanes whose byteEn bit is set. Bad parity on a disabled lane causes no error.
- R4: In deferred mode a CPU access ends at 2 clocks. A CPU read with bad parity still ends with cycDone, and stickyErr goes high after it.
- R5: In deferred mode, while stickyErr is high, every CPU access (read or write) ends with busErr at 2 clocks instead of cycDone.
- R6: In deferred mode a non-CPU access ends at 3 clocks. A read with bad parity ends with busErr; any other access ends with cycDone.
- R7: In strict mode every access from any master ends at 3 clocks. A read with bad parity ends with busErr; any other access ends with cycDone.
- R8: cycDone and busErr are never high together. Each access produces exactly one pulse, one clock long. cycStart is ignored while an access is in progress.
- R9: stickyErr clears on a clrSticky pulse or on any change of modeSel. A clear takes priority over a set in the same clock.
- R10: The mode is taken at the start of an access. Changing modeSel during the access does not change its length or its error policy.
- R11: After reset, cycDone, busErr and stickyErr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | Parity policy select |
| masterId | input | 2 | Identity of the bus owner, 0 = CPU |
| cycStart | input | 1 | Starts an access when idle |
| wrEn | input | 1 | 1 = write, 0 = read |
| byteEn | input | DW/8 | Byte lane enables |
| wrData | input | DW | Write data from the master |
| rdData | input | DW | Data returned by the DRAM |
| rdParity | input | DW/8 | Stored parity bits returned by the DRAM |
| clrSticky | input | 1 | Clears the deferred error flag |
| parOut | output | DW/8 | Parity bits to store on a write |
| cycDone | output | 1 | Access completed normally |
| busErr | output | 1 | Access terminated with error |
| stickyErr | output | 1 | Deferred CPU parity error pending |

## Verification
The accesses run in each mode with a CPU master and with two non-CPU masters, as clean reads, as reads with corrupted parity on an enabled lane, as reads with corrupted parity on a disabled lane only, and as writes. These separate the 2- and 3-clock lengths and the immediate from the deferred report. A CPU write issued after a deferred error shows that the flag taxes every later CPU access and not only reads. The flag is cleared both by the clear input and by a mode change. Finally, a mode flip and a held start during a busy access show that the values latched at the start govern the whole access.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_DEFER  = 2'd1,
    MODE_STRICT = 2'd2
  } parMode_t;

  typedef struct packed {
    logic capture;   // latch lane enables of a new access
    logic checkEn;   // evaluate parity of returned read data
  } ctrlStrobe_t;

  function automatic parMode_t decodeMode(input logic [1:0] sel);
    case (sel)
      2'd0:    return MODE_OFF;
      2'd1:    return MODE_DEFER;
      default: return MODE_STRICT;
    endcase
  endfunction

endpackage

// File: rtl/dpc_datapath.sv
module dpc_datapath
  import dpc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DW/8-1:0]   byteEn,
  input  logic [DW-1:0]     wrData,
  input  logic [DW-1:0]     rdData,
  input  logic [DW/8-1:0]   rdParity,
  output logic [DW/8-1:0]   parOut,
  output logic              parErr
);
  localparam int NB = DW / 8;

  logic [NB-1:0] laneEn;
  logic [NB-1:0] laneBad;

  always_ff @(posedge clk) begin
    if (!rstN) laneEn <= '0;
    else if (strobe.capture) laneEn <= byteEn;
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    // odd parity: stored bit makes total count of ones odd
    assign parOut[i]  = byteEn[i] & ~(^wrData[8*i +: 8]);
    assign laneBad[i] = laneEn[i] & ~((^rdData[8*i +: 8]) ^ rdParity[i]);
  end

  assign parErr = strobe.checkEn & (|laneBad);

  // R3
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(laneEn));

endmodule

// File: rtl/dpc_control.sv
module dpc_control
  import dpc_pkg::*;
#(
  parameter int BASE_CLKS = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  modeSel,
  input  logic [1:0]  masterId,
  input  logic        cycStart,
  input  logic        wrEn,
  input  logic        clrSticky,
  input  logic        parErr,
  output ctrlStrobe_t strobe,
  output logic        cycDone,
  output logic        busErr,
  output logic        stickyErr
);
  localparam int EXT_CLKS = BASE_CLKS + 1;
  localparam int CW       = $clog2(EXT_CLKS + 1);
  localparam logic [CW-1:0] BASE_CNT = CW'(BASE_CLKS);
  localparam logic [CW-1:0] EXT_CNT  = CW'(EXT_CLKS);

  logic          active;
  logic [CW-1:0] cnt;
  parMode_t      curMode;
  logic          isCpu;
  logic          isRead;
  logic          errHold;
  logic          sticky;
  logic [1:0]    prevMode;

  logic stretch, checkOn, lastPhase, errOut, setSticky, clrNow;

  always_comb begin
    stretch   = (curMode == MODE_STRICT) || (curMode == MODE_DEFER && !isCpu);
    checkOn   = (curMode != MODE_OFF);
    lastPhase = active && (cnt == (stretch ? EXT_CNT : BASE_CNT));
    strobe.capture = !active && cycStart;
    strobe.checkEn = active && isRead && checkOn && (cnt == BASE_CNT);
    setSticky = parErr && (curMode == MODE_DEFER) && isCpu;
    clrNow    = clrSticky || (modeSel != prevMode);
    errOut    = stretch ? errHold : ((curMode == MODE_DEFER) && isCpu && sticky);
    cycDone   = lastPhase && !errOut;
    busErr    = lastPhase && errOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      cnt      <= '0;
      curMode  <= MODE_OFF;
      isCpu    <= 1'b0;
      isRead   <= 1'b0;
      errHold  <= 1'b0;
      sticky   <= 1'b0;
      prevMode <= 2'd0;
    end else begin
      prevMode <= modeSel;
      if (!active) begin
        if (cycStart) begin
          active  <= 1'b1;
          cnt     <= CW'(1);
          curMode <= decodeMode(modeSel);
          isCpu   <= (masterId == 2'd0);
          isRead  <= !wrEn;
          errHold <= 1'b0;
        end
      end else if (lastPhase) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + CW'(1);
        if (strobe.checkEn) errHold <= parErr;
      end
      if (clrNow) sticky <= 1'b0;
      else if (setSticky) sticky <= 1'b1;
    end
  end

  assign stickyErr = sticky;

  // R8
  excl_term_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cycDone && busErr));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cycDone || busErr) |=> !(cycDone || busErr));
  // R1
  off_no_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && curMode == MODE_OFF) |-> !busErr);
  // R7
  strict_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && curMode == MODE_STRICT && cnt == BASE_CNT) |-> !(cycDone || busErr));
  // R4
  sticky_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sticky) |-> ($past(curMode) == MODE_DEFER && $past(isCpu)));
  // R9
  sticky_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrSticky |=> !sticky);

endmodule

// File: rtl/dram_parity_ctrl.sv
module dram_parity_ctrl
  import dpc_pkg::*;
#(
  parameter int DW        = 32,
  parameter int BASE_CLKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic [1:0]        masterId,
  input  logic              cycStart,
  input  logic              wrEn,
  input  logic [DW/8-1:0]   byteEn,
  input  logic [DW-1:0]     wrData,
  input  logic [DW-1:0]     rdData,
  input  logic [DW/8-1:0]   rdParity,
  input  logic              clrSticky,
  output logic [DW/8-1:0]   parOut,
  output logic              cycDone,
  output logic              busErr,
  output logic              stickyErr
);
  ctrlStrobe_t strobe;
  logic        parErr;

  dpc_control #(.BASE_CLKS(BASE_CLKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .masterId(masterId),
    .cycStart(cycStart), .wrEn(wrEn), .clrSticky(clrSticky), .parErr(parErr),
    .strobe(strobe), .cycDone(cycDone), .busErr(busErr), .stickyErr(stickyErr)
  );

  dpc_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteEn(byteEn), .wrData(wrData),
    .rdData(rdData), .rdParity(rdParity), .parOut(parOut), .parErr(parErr)
  );

endmodule

// File: tb/sim_dram_parity_ctrl.sv
module sim_dram_parity_ctrl;
  localparam int CLK_PER = 10;
  localparam int DW = 32;
  localparam int NB = DW / 8;

  logic clk = 0, rstN = 0;
  logic [1:0] modeSel = 0, masterId = 0;
  logic cycStart = 0, wrEn = 0, clrSticky = 0;
  logic [NB-1:0] byteEn = '1, rdParity = '0, parOut;
  logic [DW-1:0] wrData = '0, rdData = '0;
  logic cycDone, busErr, stickyErr;

  int errCnt = 0, chkCnt = 0;
  logic [DW-1:0] memD [8];
  logic [NB-1:0] memP [8];

  always #(CLK_PER/2) clk = ~clk;

  dram_parity_ctrl u0 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .masterId(masterId),
    .cycStart(cycStart), .wrEn(wrEn), .byteEn(byteEn), .wrData(wrData),
    .rdData(rdData), .rdParity(rdParity), .clrSticky(clrSticky),
    .parOut(parOut), .cycDone(cycDone), .busErr(busErr), .stickyErr(stickyErr)
  );

  task automatic check(input string tag, input int act, input int exp);
    chkCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] oddPar(input logic [DW-1:0] d, input logic [NB-1:0] be);
    logic [NB-1:0] p;
    for (int i = 0; i < NB; i++) p[i] = be[i] & ~(^d[8*i +: 8]);
    return p;
  endfunction

  // Runs one access; expLen = clocks to termination, expErr = busErr expected.
  // flipMode: change modeSel to this value after start (-1 = none); holdStart keeps cycStart high.
  task automatic runCycle(input string tag, input logic [1:0] mode, input logic [1:0] mst,
                          input logic wr, input int addr, input logic [NB-1:0] be,
                          input logic [DW-1:0] d, input logic [NB-1:0] corrupt,
                          input int expLen, input logic expErr,
                          input int flipMode = -1, input bit holdStart = 0);
    int doneAt = 0, errAt = 0, pulses = 0;
    @(negedge clk);
    modeSel = mode; masterId = mst; wrEn = wr; byteEn = be; wrData = d;
    rdData = memD[addr]; rdParity = memP[addr] ^ corrupt;
    if (wr) begin
      memD[addr] = d;
      memP[addr] = oddPar(d, '1);
    end
    cycStart = 1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (!holdStart || k >= 3) cycStart = 0;
      if (k == 1 && flipMode >= 0) modeSel = 2'(flipMode);
      if (cycDone) begin pulses++; if (doneAt == 0) doneAt = k; end
      if (busErr)  begin pulses++; if (errAt == 0) errAt = k; end
      if (cycDone && busErr) check({tag, " R8 exclusive"}, 1, 0);
    end
    check({tag, " R8 single pulse"}, pulses, 1);
    check({tag, " length"}, expErr ? errAt : doneAt, expLen);
    check({tag, " error kind"}, int'(errAt != 0), int'(expErr));
    if (flipMode >= 0) begin
      @(negedge clk); modeSel = mode;
    end
  endtask

  task automatic doReset();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R11 reset done", cycDone, 0);
    check("R11 reset busErr", busErr, 0);
    check("R11 reset sticky", stickyErr, 0);
  endtask

  task automatic testParityGen();
    logic [DW-1:0] pats [4] = '{32'h0000_0000, 32'hFF01_8003, 32'h1234_5678, 32'hFFFF_FFFF};
    logic [NB-1:0] ens  [4] = '{4'hF, 4'hF, 4'h5, 4'hA};
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      wrData = pats[j]; byteEn = ens[j];
      #1 check("R2 parity gen", parOut, oddPar(pats[j], ens[j]));
    end
  endtask

  task automatic testUnchecked();
    runCycle("R1 off write", 2'd0, 2'd0, 1, 0, 4'hF, 32'hA5A5_0F0F, 0, 2, 0);
    runCycle("R1 off bad read", 2'd0, 2'd0, 0, 0, 4'hF, 0, 4'h2, 2, 0);
    runCycle("R1 off dma bad read", 2'd0, 2'd1, 0, 0, 4'hF, 0, 4'h1, 2, 0);
  endtask

  task automatic testDeferred();
    runCycle("R4 cpu write", 2'd1, 2'd0, 1, 1, 4'hF, 32'h0102_0304, 0, 2, 0);
    runCycle("R4 cpu good read", 2'd1, 2'd0, 0, 1, 4'hF, 0, 0, 2, 0);
    check("R4 sticky still low", stickyErr, 0);
    runCycle("R4 cpu bad read", 2'd1, 2'd0, 0, 1, 4'hF, 0, 4'h4, 2, 0);
    check("R4 sticky set", stickyErr, 1);
    runCycle("R5 cpu write after err", 2'd1, 2'd0, 1, 2, 4'hF, 32'h7, 0, 2, 1);
    runCycle("R5 cpu good read after err", 2'd1, 2'd0, 0, 1, 4'hF, 0, 0, 2, 1);
    runCycle("R6 dma bad read", 2'd1, 2'd1, 0, 1, 4'hF, 0, 4'h8, 3, 1);
    runCycle("R6 dma good read", 2'd1, 2'd1, 0, 1, 4'hF, 0, 0, 3, 0);
    runCycle("R6 net write", 2'd1, 2'd2, 1, 3, 4'h3, 32'hBEEF, 0, 3, 0);
    check("R6 sticky untouched by others", stickyErr, 1);
  endtask

  task automatic testClear();
    @(negedge clk); clrSticky = 1;
    @(negedge clk); clrSticky = 0;
    check("R9 clear by input", stickyErr, 0);
    runCycle("R9 cpu after clear", 2'd1, 2'd0, 0, 1, 4'hF, 0, 0, 2, 0);
    runCycle("R9 cpu bad read again", 2'd1, 2'd0, 0, 1, 4'hF, 0, 4'h1, 2, 0);
    check("R9 sticky set again", stickyErr, 1);
    @(negedge clk); modeSel = 2'd2;
    @(negedge clk);
    check("R9 clear by mode change", stickyErr, 0);
    // clear and set in the same clock: bad deferred CPU read while clrSticky held
    @(negedge clk); modeSel = 2'd1;
    @(negedge clk); clrSticky = 1;
    runCycle("R9 cpu bad read during clear", 2'd1, 2'd0, 0, 1, 4'hF, 0, 4'h1, 2, 0);
    clrSticky = 0;
    check("R9 clear wins", stickyErr, 0);
  endtask

  task automatic testStrict();
    runCycle("R7 cpu bad read", 2'd2, 2'd0, 0, 1, 4'hF, 0, 4'h2, 3, 1);
    runCycle("R7 cpu good read", 2'd2, 2'd0, 0, 1, 4'hF, 0, 0, 3, 0);
    runCycle("R7 cpu write", 2'd3, 2'd0, 1, 4, 4'hF, 32'hCAFE_F00D, 0, 3, 0);
    runCycle("R7 ext bad read", 2'd3, 2'd3, 0, 4, 4'hF, 0, 4'h8, 3, 1);
    check("R7 no sticky in strict", stickyErr, 0);
    runCycle("R3 bad on disabled lane", 2'd2, 2'd1, 0, 4, 4'h3, 0, 4'hC, 3, 0);
    runCycle("R3 bad on enabled lane", 2'd2, 2'd1, 0, 4, 4'h3, 0, 4'h2, 3, 1);
  endtask

  task automatic testLatching();
    runCycle("R10 strict then flip to off", 2'd2, 2'd0, 0, 4, 4'hF, 0, 4'h1, 3, 1, 0);
    runCycle("R10 off then flip to strict", 2'd0, 2'd0, 0, 4, 4'hF, 0, 4'h1, 2, 0, 2);
    runCycle("R8 start held while busy", 2'd2, 2'd1, 0, 4, 4'hF, 0, 0, 3, 0, -1, 1);
  endtask

  initial begin
    for (int a = 0; a < 8; a++) begin memD[a] = '0; memP[a] = '1; end
    doReset();
    testParityGen();
    testUnchecked();
    testDeferred();
    testClear();
    testStrict();
    testLatching();
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    #(CLK_PER * 100000);
    errCnt++; chkCnt++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule